// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Decoder

This block sits on the write side of an 8-bit CPU bus inside a cartridge memory mapper. It holds eight character bank numbers (one for each 1 KB slice of an 8 KB character space), one 16 KB program bank number and a two-bit nametable mirroring code. Writes reach these registers through a decode window. A build-time variant picks that window: 0x6000–0x7FFF only, 0x8000–0xFFFF only, or both. Inside the window, the low four address bits select the register.

From the current register values, the block forms two translated ROM addresses with no added latency. A CPU read in the lower 16 KB program window is sent to the selected program bank. A read in the upper 16 KB window always goes to the last fitted bank. A character-bus address is sent to the bank held by its 1 KB slot. Each bank number is reduced modulo the number of banks actually fitted. The interrupt counter that shares this register space is a separate block, so its indices have no effect here.

Top module: `cart_bank_decoder`

## Requirements
- R1: With VARIANT=0 only writes with cpu_addr in 0x6000–0x7FFF reach the registers. With VARIANT=1 only 0x8000–0xFFFF does. With VARIANT=2 both ranges do.
- R2: A write whose address is outside the enabled window changes no register. This includes every address below 0x6000.
- R3: A write to register index 0–7 (cpu_addr[3:0]) loads all eight data bits into the character bank register of that slot.
- R4: A write to index 8 stores cpu_data[3:0] as the program bank number. The upper data bits are dropped.
- R5: When prg_rd_addr[14] is 0 (CPU 0x8000–0xBFFF), prg_rom_addr equals {selected program bank, prg_rd_addr[13:0]}.
- R6: When prg_rd_addr[14] is 1 (CPU 0xC000–0xFFFF), prg_rom_addr equals {PRG_BANKS-1, prg_rd_addr[13:0]}, whatever the program bank register holds.
- R7: A write to index 9 sets mirror_mode to cpu_data[1:0]. The codes are 0 vertical, 1 horizontal, 2 single-screen lower page, 3 single-screen upper page.
- R8: Writes to indices 10–15 leave all bank registers and the mirroring code unchanged.
- R9: chr_addr[12:10] selects slot i, which covers i×0x400 to i×0x400+0x3FF. chr_mem_addr equals {bank of that slot, chr_addr[9:0]}.
- R10: Reset (rst_n low) clears every bank register and the mirroring code to 0.
- R11: Program and character bank numbers are reduced modulo PRG_BANKS and CHR_BANKS before they form the translated address.
- R12: A register write takes effect at the rising clock edge where cpu_wr is sampled high. The translated addresses follow the registers combinationally from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle for each write |
| prg_rd_addr | input | 15 | Low 15 bits of a CPU read address in 0x8000–0xFFFF |
| chr_addr | input | 13 | Character-bus address within the 8 KB space |
| prg_rom_addr | output | $clog2(PRG_BANKS)+14 | Translated program ROM address |
| chr_mem_addr | output | $clog2(CHR_BANKS)+10 | Translated character memory address |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
A bank register write and a character fetch through that same slot can fall in one cycle. This happens when a CPU store retargets a 1 KB slice while rendering is reading from it. The bench holds chr_addr inside slot 3 and drives a write to index 3 during that cycle. It then judges chr_mem_addr twice: just before the rising edge, where the old bank must still show, and just after it, where the new bank must show. Three instances, one for each variant, share the same bus, so a single write also shows which window decodes accept or drop it.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 4;
    localparam int PRG_REG_W  = 4;
    localparam int NUM_SLOTS  = 8;
    localparam int SLOT_SEL_W = $clog2(NUM_SLOTS);
    localparam int SLOT_OFS_W = 10;   // 1 KB character slice
    localparam int PRG_OFS_W  = 14;   // 16 KB program window

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][DATA_W-1:0] chr;
        logic [PRG_REG_W-1:0]             prg;
        mirror_e                          mir;
    } bank_state_t;
endpackage

// File: rtl/cbd_write_decode.sv
module cbd_write_decode #(
    parameter int VARIANT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [15:0]             cpu_addr,
    input  logic                    cpu_wr,
    output logic                    hit,
    output logic [cbd_pkg::IDX_W-1:0] idx
);
    logic in_low;
    logic in_high;
    logic accept;

    assign in_low  = (cpu_addr[15:13] == 3'b011);
    assign in_high = cpu_addr[15];

    generate
        if (VARIANT == 0) begin : g_low_only
            assign accept = in_low;
        end else if (VARIANT == 1) begin : g_high_only
            assign accept = in_high;
        end else begin : g_both
            assign accept = in_low | in_high;
        end
    endgenerate

    assign hit = cpu_wr & accept;
    assign idx = cpu_addr[cbd_pkg::IDX_W-1:0];

    // R1: an accepted write lies inside a window the variant enables
    assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((VARIANT != 0 && cpu_addr >= 16'h8000) ||
                 (VARIANT != 1 && cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF)));

    // R2: nothing below 0x6000 is ever accepted
    assert_low_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr < 16'h6000) |-> !hit);
endmodule

// File: rtl/cbd_regfile.sv
module cbd_regfile (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hit,
    input  logic [cbd_pkg::IDX_W-1:0]     idx,
    input  logic [cbd_pkg::DATA_W-1:0]    data,
    output cbd_pkg::bank_state_t          st_q
);
    import cbd_pkg::*;

    bank_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            if (idx < IDX_W'(NUM_SLOTS)) begin
                st_d.chr[idx[SLOT_SEL_W-1:0]] = data;
            end else if (idx == 4'd8) begin
                st_d.prg = data[PRG_REG_W-1:0];
            end else if (idx == 4'd9) begin
                st_d.mir = mirror_e'(data[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: state is cleared on the first edge after reset
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q == '0));

    // R2: no accepted write means no state change
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q));

    // R3: slot load
    assert_chr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx < 4'd8) |=> (st_q.chr[$past(idx[SLOT_SEL_W-1:0])] == $past(data)));

    // R4: program bank keeps low nibble
    assert_prg_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx == 4'd8) |=> (st_q.prg == $past(data[PRG_REG_W-1:0])));

    // R7: mirroring code load
    assert_mirror_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx == 4'd9) |=> (st_q.mir == $past(data[1:0])));

    // R8: upper indices leave state alone
    assert_upper_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx >= 4'd10) |=> $stable(st_q));
endmodule

// File: rtl/cbd_prg_map.sv
module cbd_prg_map #(
    parameter int PRG_BANKS = 8,
    localparam int PRG_BW   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int PRG_AW   = PRG_BW + cbd_pkg::PRG_OFS_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [cbd_pkg::PRG_REG_W-1:0]     bank_reg,
    input  logic [cbd_pkg::PRG_OFS_W:0]       rd_addr,
    output logic [PRG_AW-1:0]                 rom_addr
);
    import cbd_pkg::*;

    localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);

    logic [PRG_BW-1:0] sel_bank;
    logic [PRG_BW-1:0] eff_bank;

    assign sel_bank = PRG_BW'(32'(bank_reg) % 32'(PRG_BANKS));
    assign eff_bank = rd_addr[PRG_OFS_W] ? LAST_BANK : sel_bank;
    assign rom_addr = {eff_bank, rd_addr[PRG_OFS_W-1:0]};

    // R6: upper window pinned to the last bank
    assert_fixed_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr[PRG_OFS_W] |-> (rom_addr[PRG_AW-1:PRG_OFS_W] == LAST_BANK));

    // R11: bank field never exceeds the fitted count
    assert_prg_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rom_addr[PRG_AW-1:PRG_OFS_W]) < 32'(PRG_BANKS));

    // R5: offset bits pass through unchanged
    assert_prg_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[PRG_OFS_W-1:0] == rd_addr[PRG_OFS_W-1:0]);
endmodule

// File: rtl/cbd_chr_map.sv
module cbd_chr_map #(
    parameter int CHR_BANKS = 128,
    localparam int CHR_BW   = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int CHR_AW   = CHR_BW + cbd_pkg::SLOT_OFS_W
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic [cbd_pkg::NUM_SLOTS-1:0][cbd_pkg::DATA_W-1:0]    chr_regs,
    input  logic [cbd_pkg::SLOT_OFS_W+cbd_pkg::SLOT_SEL_W-1:0]    chr_addr,
    output logic [CHR_AW-1:0]                                     mem_addr
);
    import cbd_pkg::*;

    logic [CHR_BW-1:0]     red_bank [NUM_SLOTS];
    logic [SLOT_SEL_W-1:0] slot;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            assign red_bank[g] = CHR_BW'(32'(chr_regs[g]) % 32'(CHR_BANKS));
        end
    endgenerate

    assign slot     = chr_addr[SLOT_OFS_W +: SLOT_SEL_W];
    assign mem_addr = {red_bank[slot], chr_addr[SLOT_OFS_W-1:0]};

    // R9: offset inside the 1 KB slice passes through
    assert_chr_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[SLOT_OFS_W-1:0] == chr_addr[SLOT_OFS_W-1:0]);

    // R11: character bank field never exceeds the fitted count
    assert_chr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        32'(mem_addr[CHR_AW-1:SLOT_OFS_W]) < 32'(CHR_BANKS));
endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder #(
    parameter int VARIANT   = 2,
    parameter int PRG_BANKS = 8,
    parameter int CHR_BANKS = 128,
    localparam int PRG_AW   = ((PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1) + 14,
    localparam int CHR_AW   = ((CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1) + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [14:0]       prg_rd_addr,
    input  logic [12:0]       chr_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [CHR_AW-1:0] chr_mem_addr,
    output logic [1:0]        mirror_mode
);
    import cbd_pkg::*;

    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;
    bank_state_t      st_q;

    cbd_write_decode #(.VARIANT(VARIANT)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .hit      (wr_hit),
        .idx      (wr_idx)
    );

    cbd_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (wr_hit),
        .idx   (wr_idx),
        .data  (cpu_data),
        .st_q  (st_q)
    );

    cbd_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_reg (st_q.prg),
        .rd_addr  (prg_rd_addr),
        .rom_addr (prg_rom_addr)
    );

    cbd_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .clk      (clk),
        .rst_n    (rst_n),
        .chr_regs (st_q.chr),
        .chr_addr (chr_addr),
        .mem_addr (chr_mem_addr)
    );

    assign mirror_mode = st_q.mir;

    // R12: translated character address moves only on a write or a bus address change
    assert_chr_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_hit) && $stable(chr_addr)) |-> $stable(chr_mem_addr));
endmodule

// File: tb/tb_cart_bank_decoder.sv
module tb_cart_bank_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [14:0] prg_rd_addr = '0;
    logic [12:0] chr_addr = '0;

    logic [16:0] prg_b, prg_lo, prg_hi;
    logic [16:0] chr_b, chr_lo, chr_hi;
    logic [1:0]  mir_b, mir_lo, mir_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_decoder #(.VARIANT(2)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .prg_rd_addr(prg_rd_addr), .chr_addr(chr_addr),
        .prg_rom_addr(prg_b), .chr_mem_addr(chr_b), .mirror_mode(mir_b));

    cart_bank_decoder #(.VARIANT(0)) dut_lo (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .prg_rd_addr(prg_rd_addr), .chr_addr(chr_addr),
        .prg_rom_addr(prg_lo), .chr_mem_addr(chr_lo), .mirror_mode(mir_lo));

    cart_bank_decoder #(.VARIANT(1)) dut_hi (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .prg_rd_addr(prg_rd_addr), .chr_addr(chr_addr),
        .prg_rom_addr(prg_hi), .chr_mem_addr(chr_hi), .mirror_mode(mir_hi));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
        cpu_addr = '0;
    endtask

    task automatic t_reset();
        prg_rd_addr = 15'h0123;
        chr_addr    = 13'h0C05;
        #1;
        chk("R10 prg after reset", 32'(prg_b), 32'h0123);
        chk("R10 chr after reset", 32'(chr_b), 32'h0005);
        chk("R10 mirror after reset", 32'(mir_b), 32'h0);
    endtask

    task automatic t_window();
        prg_rd_addr = 15'h0000;
        wr(16'h6008, 8'h02);
        chk("R1 both takes low window", 32'(prg_b), 32'(2) << 14);
        chk("R1 low variant takes low window", 32'(prg_lo), 32'(2) << 14);
        chk("R1 high variant drops low window", 32'(prg_hi), 32'(0));
        wr(16'h8008, 8'h04);
        chk("R1 both takes high window", 32'(prg_b), 32'(4) << 14);
        chk("R1 low variant drops high window", 32'(prg_lo), 32'(2) << 14);
        chk("R1 high variant takes high window", 32'(prg_hi), 32'(4) << 14);
        wr(16'h5008, 8'h06);
        chk("R2 below 0x6000 ignored both", 32'(prg_b), 32'(4) << 14);
        chk("R2 below 0x6000 ignored low", 32'(prg_lo), 32'(2) << 14);
        wr(16'h4009, 8'h03);
        chk("R2 mirror write outside window ignored", 32'(mir_b), 32'(0));
        wr(16'hE008, 8'h01);
        chk("R1 both takes 0xE008", 32'(prg_b), 32'(1) << 14);
        chk("R2 low variant drops 0xE008", 32'(prg_lo), 32'(2) << 14);
        chk("R1 high variant takes 0xE008", 32'(prg_hi), 32'(1) << 14);
    endtask

    task automatic t_chr_slots();
        for (int i = 0; i < 8; i++) wr(16'h8000 + 16'(i), 8'(i * 3 + 1));
        for (int i = 0; i < 8; i++) begin
            chr_addr = 13'(i * 32'h400);
            #1;
            chk("R9 slot lower edge", 32'(chr_b), 32'(i * 3 + 1) << 10);
            chr_addr = 13'(i * 32'h400 + 32'h3FF);
            #1;
            chk("R3 slot upper edge", 32'(chr_b), (32'(i * 3 + 1) << 10) | 32'h3FF);
        end
    endtask

    task automatic t_prg();
        wr(16'h8008, 8'hF5);
        prg_rd_addr = 15'h1234;
        #1;
        chk("R4 upper data bits dropped", 32'(prg_b), (32'(5) << 14) | 32'h1234);
        prg_rd_addr = 15'h3FFF;
        #1;
        chk("R5 top of switchable window", 32'(prg_b), (32'(5) << 14) | 32'h3FFF);
        prg_rd_addr = 15'h4000;
        #1;
        chk("R6 fixed window base", 32'(prg_b), 32'(7) << 14);
        prg_rd_addr = 15'h7FFF;
        #1;
        chk("R6 fixed window top", 32'(prg_b), (32'(7) << 14) | 32'h3FFF);
    endtask

    task automatic t_modulo();
        wr(16'h8008, 8'h0B);
        prg_rd_addr = 15'h0010;
        #1;
        chk("R11 prg 11 mod 8", 32'(prg_b), (32'(3) << 14) | 32'h10);
        wr(16'h8002, 8'h85);
        chk_slot2();
    endtask

    task automatic chk_slot2();
        chr_addr = 13'h0808;
        #1;
        chk("R11 chr 133 mod 128", 32'(chr_b), (32'(5) << 10) | 32'h008);
    endtask

    task automatic t_mirror();
        for (int m = 0; m < 4; m++) begin
            wr(16'h8009, 8'hFC | 8'(m));
            chk("R7 mirror code", 32'(mir_b), 32'(m));
        end
    endtask

    task automatic t_upper_idx();
        for (int k = 10; k < 16; k++) wr(16'h8000 + 16'(k), 8'hFF);
        prg_rd_addr = 15'h0000;
        #1;
        chk("R8 prg unchanged", 32'(prg_b), 32'(3) << 14);
        chk("R8 mirror unchanged", 32'(mir_b), 32'(3));
        for (int i = 0; i < 8; i++) begin
            chr_addr = 13'(i * 32'h400);
            #1;
            chk("R8 chr slot unchanged", 32'(chr_b),
                (i == 2) ? (32'(5) << 10) : (32'(i * 3 + 1) << 10));
        end
    endtask

    task automatic t_same_cycle();
        chr_addr = 13'h0C10;
        wr(16'h8003, 8'h09);
        @(negedge clk);
        cpu_addr = 16'h8003;
        cpu_data = 8'h21;
        cpu_wr   = 1'b1;
        #1;
        chk("R12 old bank before edge", 32'(chr_b), (32'(9) << 10) | 32'h10);
        @(negedge clk);
        cpu_wr = 1'b0;
        chk("R12 new bank after edge", 32'(chr_b), (32'h21 << 10) | 32'h10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_chr_slots();
        t_prg();
        t_modulo();
        t_mirror();
        t_upper_idx();
        t_same_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule